// File: doc/BRIEF.md
# Switching Clock Source Selector

This block decides which timing source paces the cycles of a switching regulator. A free-running internal oscillator provides a one-cycle tick in the fast system clock domain. An external synchronization pin may carry a faster or slower clock. The block emits one start-of-cycle pulse per regulator cycle and a flag that shows which source is in control. Everything runs on one system clock with a synchronous active-high reset.

The raw sync pin passes through a synchronizer, and then its rising edges are detected. The first rising edge takes control at once, and that edge starts a cycle. While the external source is in control, each internal tick is counted. Every sync edge clears the count. When a set number of internal periods pass with no sync edge, control goes back to the internal tick. The tick that ends this timeout also starts a cycle, so the regulator never loses a cycle during the change. While soft start is active, the sync pin has no effect and the internal tick paces every cycle.

Top module: `cyc_src_sel`

## Requirements
- R1: After reset, `ext_sel` is 0 (internal source) and `cyc_start` is 0.
- R2: When the internal source is selected, each one-cycle `int_tick` gives a one-cycle `cyc_start` on the next clock edge.
- R3: `sync_raw` passes through a two-stage synchronizer. A 0-to-1 change on `sync_raw` before clock edge k gives `cyc_start`=1 and `ext_sel`=1 after edge k+2. This happens on the first such edge, with no qualifying delay.
- R4: When the external source is selected, `int_tick` does not give `cyc_start` unless it ends the timeout of R6.
- R5: When the external source is selected, each sync rising edge gives exactly one `cyc_start` pulse. A sync level that stays high gives no further pulses.
- R6: When the external source is selected and 2 internal ticks (parameter MISS_PERIODS) pass with no sync rising edge, the second tick gives `cyc_start` on the next edge and `ext_sel` returns to 0 on that same edge.
- R7: A sync rising edge clears the missing-edge tick count, so a tick before an edge and a tick after it do not cause a fallback.
- R8: While `ss_active`=1, sync edges are ignored. They give no `cyc_start` and no change to `ext_sel`, and every `int_tick` starts a cycle.
- R9: When `ss_active` rises while the external source is selected, `ext_sel` returns to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| int_tick | input | 1 | One-cycle pulse from the internal oscillator, once per internal period |
| sync_raw | input | 1 | Asynchronous external synchronization pin |
| ss_active | input | 1 | High while soft start is running |
| cyc_start | output | 1 | One-cycle pulse that starts a regulator switching cycle |
| ext_sel | output | 1 | 1 = external sync selected, 0 = internal tick selected |

## Verification
The hardest case to reach is the fallback edge. In that case the external source is selected, the sync line has gone quiet, and exactly the counted number of internal ticks have passed. Only then must the last tick start a cycle while the flag drops on the same edge. To reach it, the stimulus locks the block to one sync edge and holds the pin at a steady level so that no new edge can form. It then sends isolated ticks one at a time and checks the pulse and the flag after each tick. A variant sends one sync edge between two ticks, which shows that the count is cleared.

// File: rtl/cyc_src_pkg.sv
package cyc_src_pkg;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_e;

    // Width of a counter that must hold values 0..n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sync_rise_det.sv
module sync_rise_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic rise
);
    // chain[0..STAGES-1] synchronizer, chain[STAGES] holds previous level
    logic [STAGES:0] chain;

    generate
        for (genvar g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // R5: a detected edge cannot repeat on the following cycle
    assert_edge_single_R5: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/miss_timer.sv
module miss_timer
    import cyc_src_pkg::*;
#(
    parameter int MISS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    localparam int CW = cnt_width(MISS);
    localparam logic [CW-1:0] LAST = CW'(MISS - 1);

    logic [CW-1:0] cnt;

    assign expire = tick & ~clr & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)   cnt <= '0;
        else if (expire)  cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    // R6: the count never passes the last missing period
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R7: a clear always leaves the count at zero
    assert_clr_zero_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/cyc_src_sel.sv
module cyc_src_sel
    import cyc_src_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int MISS_PERIODS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic int_tick,
    input  logic sync_raw,
    input  logic ss_active,
    output logic cyc_start,
    output logic ext_sel
);
    src_e sel;
    logic rise;
    logic rise_ok;
    logic tmr_clr;
    logic tmr_expire;
    logic timeout;
    logic start_now;

    sync_rise_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .pin_async (sync_raw),
        .rise      (rise)
    );

    assign rise_ok = rise & ~ss_active;
    assign tmr_clr = rise_ok | ss_active | (sel == SRC_INT);

    miss_timer #(.MISS(MISS_PERIODS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (tmr_clr),
        .tick   (int_tick),
        .expire (tmr_expire)
    );

    assign timeout   = tmr_expire & (sel == SRC_EXT);
    assign start_now = rise_ok |
                       (int_tick & ((sel == SRC_INT) | ss_active | timeout));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel       <= SRC_INT;
            cyc_start <= 1'b0;
        end else begin
            cyc_start <= start_now;
            if (ss_active)    sel <= SRC_INT;
            else if (rise_ok) sel <= SRC_EXT;
            else if (timeout) sel <= SRC_INT;
        end
    end

    assign ext_sel = (sel == SRC_EXT);

    // R3: taking the external source always starts a cycle
    assert_ext_entry_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_sel) |-> cyc_start);

    // R6: a fallback outside soft start starts a cycle on the same edge
    assert_fallback_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(ext_sel) && !$past(ss_active)) |-> cyc_start);

    // R8: soft start keeps the internal source
    assert_ss_internal_R8: assert property (@(posedge clk) disable iff (rst)
        ss_active |=> !ext_sel);

    // R8: during steady soft start, pulses follow ticks only
    assert_ss_tick_only_R8: assert property (@(posedge clk) disable iff (rst)
        (ss_active && $past(ss_active)) |=> (cyc_start == $past(int_tick)));

endmodule

// File: tb/cyc_src_sel_test.sv
module cyc_src_sel_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic int_tick = 1'b0;
    logic sync_raw = 1'b0;
    logic ss_active = 1'b0;
    logic cyc_start;
    logic ext_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cyc_src_sel uut (
        .clk       (clk),
        .rst       (rst),
        .int_tick  (int_tick),
        .sync_raw  (sync_raw),
        .ss_active (ss_active),
        .cyc_start (cyc_start),
        .ext_sel   (ext_sel)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // drive one tick; returns cyc_start seen after the capturing edge
    task automatic tick_once(output logic seen);
        int_tick = 1'b1;
        @(negedge clk);
        int_tick = 1'b0;
        seen = cyc_start;
    endtask

    // low then high on sync; returns cyc_start seen after edge k+2
    task automatic sync_rise(output logic seen);
        sync_raw = 1'b0;
        repeat (4) @(negedge clk);
        sync_raw = 1'b1;
        repeat (3) @(negedge clk);
        seen = cyc_start;
    endtask

    task automatic do_reset();
        rst = 1'b1; int_tick = 1'b0; sync_raw = 1'b0; ss_active = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 ext_sel", ext_sel, 1'b0);
        chk("R1 cyc_start", cyc_start, 1'b0);
    endtask

    task automatic t_internal();
        logic s;
        for (int i = 0; i < 3; i++) begin
            tick_once(s);
            chk("R2 tick pulse", s, 1'b1);
            @(negedge clk);
            chk("R2 pulse width", cyc_start, 1'b0);
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic t_lock_and_follow();
        logic s;
        do_reset();
        sync_raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 no early pulse", cyc_start, 1'b0);
        chk("R3 no early select", ext_sel, 1'b0);
        @(negedge clk);
        chk("R3 first edge pulse", cyc_start, 1'b1);
        chk("R3 select external", ext_sel, 1'b1);
        // R5: level held high gives nothing more
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R5 held high quiet", cyc_start, 1'b0);
        end
        tick_once(s);
        chk("R4 tick ignored", s, 1'b0);
        chk("R4 stays external", ext_sel, 1'b1);
        sync_rise(s);
        chk("R5 edge pulse", s, 1'b1);
        @(negedge clk);
        chk("R5 single pulse", cyc_start, 1'b0);
    endtask

    task automatic t_clear_by_edge();
        logic s;
        // external selected with count zero after t_lock_and_follow
        tick_once(s);
        chk("R7 first tick no pulse", s, 1'b0);
        sync_rise(s);
        chk("R7 edge pulse", s, 1'b1);
        repeat (3) @(negedge clk);
        tick_once(s);
        chk("R7 tick after edge no pulse", s, 1'b0);
        chk("R7 still external", ext_sel, 1'b1);
    endtask

    task automatic t_fallback();
        logic s;
        // count now 1: next tick is the second missing period
        repeat (4) @(negedge clk);
        tick_once(s);
        chk("R6 timeout pulse", s, 1'b1);
        chk("R6 back to internal", ext_sel, 1'b0);
        @(negedge clk);
        chk("R6 pulse width", cyc_start, 1'b0);
        tick_once(s);
        chk("R6 internal tick pulse", s, 1'b1);
    endtask

    task automatic t_fallback_fresh();
        logic s;
        sync_rise(s);
        chk("R3 relock pulse", s, 1'b1);
        chk("R3 relock select", ext_sel, 1'b1);
        tick_once(s);
        chk("R4 tick one quiet", s, 1'b0);
        chk("R6 after one tick external", ext_sel, 1'b1);
        repeat (3) @(negedge clk);
        tick_once(s);
        chk("R6 second tick pulse", s, 1'b1);
        chk("R6 second tick internal", ext_sel, 1'b0);
    endtask

    task automatic t_soft_start();
        logic s;
        do_reset();
        ss_active = 1'b1;
        @(negedge clk);
        sync_rise(s);
        chk("R8 edge ignored pulse", s, 1'b0);
        chk("R8 edge ignored select", ext_sel, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8 still internal", ext_sel, 1'b0);
        tick_once(s);
        chk("R8 tick pulse", s, 1'b1);
        ss_active = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 held level not an edge", ext_sel, 1'b0);
    endtask

    task automatic t_ss_abort();
        logic s;
        sync_rise(s);
        chk("R3 lock before abort", ext_sel, 1'b1);
        ss_active = 1'b1;
        @(negedge clk);
        chk("R9 abort to internal", ext_sel, 1'b0);
        tick_once(s);
        chk("R9 tick paces cycle", s, 1'b1);
        ss_active = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_internal();
        t_lock_and_follow();
        t_clear_by_edge();
        t_fallback();
        t_fallback_fresh();
        t_soft_start();
        t_ss_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule